// File: doc/BRIEF.md
# Power-Management Timer and Event Controller

This block is a small register-mapped power-management unit that sits behind a 64-byte I/O window. It has a free-running timer that advances on a tick-enable input, a sticky status register, an enable register and a control register. It drives a level-sensitive system-control interrupt, `sci_o`. That interrupt is high while any status bit in the interrupting subset is both set and enabled.

Software clears status bits by writing ones to them. Clearing the timer-overflow bit moves the overflow boundary to the next half-range point above the current count, so overflow keeps firing at regular intervals for as long as software services it. Writes to the control register can trigger a sleep request: one sleep type gives a power-off pulse, another records a wake event and gives a hardware-reset pulse. A separate one-byte command port turns the interrupt-mode bit on or off, and it can raise an SMI pulse.

The bus side uses a region hit, a 6-bit byte offset, a 16-bit write value and a 32-bit read value that is combinational. The timer width `TMR_W` is a parameter and defaults to 24 bits.

Top module: `pm_event_ctrl`

## Requirements
- R1: The timer count increases by one on each clock edge where `tick_i` is high, holds when `tick_i` is low, and wraps modulo 2^TMR_W. It reads at offset 0x08, zero-extended to 32 bits.
- R2: Read data is combinational from `off_i`. Offset 0x00 gives status, 0x02 enable and 0x04 control, each zero-extended from 16 bits. Offsets 0x0C, 0x18, 0x1C, 0x30, 0x31 and 0x32 read 0. Every other offset reads 0xFFFFFFFF, and so does any read while `hit_i` is low.
- R3: While `io_en_i` is low, reads return 0xFFFFFFFF and register writes have no effect.
- R4: A status write clears each bit written as 1 and leaves the others unchanged. The event inputs set bit 10 (`rtc_evt_i`), bit 8 (`pwrbtn_evt_i`) and bit 5 (`gbl_evt_i`). If an event and a clear of the same bit happen in the same cycle, the event wins.
- R5: Status bit 0 is set on the edge after the count reaches the overflow boundary. After reset the boundary is 2^TMR_W-1. A status write that clears bit 0 while bit 0 is set moves the boundary to (count + 2^(TMR_W-1)) with its low TMR_W-1 bits cleared, using the count in that cycle. In the cycle of that clear, the clear wins over a new overflow. The comparison uses a count one bit wider than the timer, so it stays correct across a wrap.
- R6: `sci_o` is registered. On each edge it takes the value "(status & enable & 0x0521) is nonzero", evaluated on the register values before that edge.
- R7: A control write stores the write value with bit 13 forced to 0. If bit 13 is written as 1, bits 12:10 select the sleep type. Type 0 gives a one-cycle `poweroff_o` pulse on the next edge. Type 1 sets status bits 15 and 8 and gives a one-cycle `reset_req_o` pulse on the next edge. Other types have no action.
- R8: A `cmd_we_i` write of 0xF1 sets control bit 0, 0xF0 clears it, and any other value leaves it unchanged. On bit 0, the command overrides a control write in the same cycle. Every command write gives a one-cycle `smi_o` pulse on the next edge, but only if `smi_en_i` is high.
- R9: After reset, status, enable, control and the timer are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer advance enable |
| io_en_i | input | 1 | Configuration bit that enables I/O decoding |
| smi_en_i | input | 1 | Configuration bit that enables the SMI pulse |
| hit_i | input | 1 | Access falls inside the window |
| we_i | input | 1 | Write strobe |
| off_i | input | 6 | Byte offset within the window |
| wdata_i | input | 16 | Write value |
| rdata_o | output | 32 | Read value (combinational) |
| rtc_evt_i | input | 1 | Sets status bit 10 |
| pwrbtn_evt_i | input | 1 | Sets status bit 8 |
| gbl_evt_i | input | 1 | Sets status bit 5 |
| cmd_we_i | input | 1 | Command port write strobe |
| cmd_i | input | 8 | Command byte |
| sci_o | output | 1 | System-control interrupt level |
| smi_o | output | 1 | SMI pulse |
| poweroff_o | output | 1 | Power-off pulse |
| reset_req_o | output | 1 | Hardware-reset request pulse |

## Verification
- **Read data** is due in the same cycle as the offset. The bench samples it 1 ns after driving the inputs, before the next rising edge.
- **Register contents and status** change on the edge that captures a write or event.
- **Pulses:** `smi_o`, `poweroff_o` and `reset_req_o` appear on that same edge and last one cycle.
- **Interrupt:** `sci_o` lags the status and enable registers by one further edge.
- **Timer overflow:** status bit 0 rises one edge after the count reaches the boundary.

The bench keeps a cycle-accurate model that advances on each rising edge. It compares every output and the read value at each falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [5:0] OFF_STS = 6'h00;
  localparam logic [5:0] OFF_EN  = 6'h02;
  localparam logic [5:0] OFF_CTL = 6'h04;
  localparam logic [5:0] OFF_TMR = 6'h08;

  localparam int B_TMR  = 0;
  localparam int B_GBL  = 5;
  localparam int B_PWR  = 8;
  localparam int B_RTC  = 10;
  localparam int B_TRIG = 13;
  localparam int B_WAKE = 15;
  localparam int B_TYP  = 10;

  localparam logic [15:0] SCI_MASK = 16'h0521;
  localparam logic [7:0]  CMD_ON   = 8'hF1;
  localparam logic [7:0]  CMD_OFF  = 8'hF0;

  typedef enum logic [2:0] {
    SLP_OFF = 3'd0,
    SLP_RAM = 3'd1
  } slp_typ_e;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rearm_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int          EW   = TMR_W + 1;
  localparam logic [EW-1:0] HALF = EW'(1) << (TMR_W - 1);
  localparam logic [EW-1:0] LOWM = HALF - EW'(1);
  localparam logic [EW-1:0] BND0 = {1'b0, {TMR_W{1'b1}}};

  logic [EW-1:0] ext_q, bnd_q, diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q <= '0;
      bnd_q <= BND0;
    end else begin
      if (tick_i) ext_q <= ext_q + EW'(1);
      if (rearm_i) bnd_q <= (ext_q + HALF) & ~LOWM;
    end
  end

  // modular distance: sign bit clear means boundary reached
  assign diff  = ext_q - bnd_q;
  assign ovf_o = ~diff[EW-1];
  assign cnt_o = ext_q[TMR_W-1:0];

  assert_tmr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == $past(cnt_o) + TMR_W'(1));
  assert_tmr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pm_sleep.sv
module pm_sleep
  import pm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctl_i,
  input  logic       trig_i,
  input  logic [2:0] typ_i,
  output logic       wake_set_o,
  output logic       poweroff_o,
  output logic       reset_req_o
);
  logic go;
  assign go         = wr_ctl_i & trig_i;
  assign wake_set_o = go & (typ_i == SLP_RAM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poweroff_o  <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      poweroff_o  <= go & (typ_i == SLP_OFF);
      reset_req_o <= wake_set_o;
    end
  end

  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(poweroff_o && reset_req_o));
  assert_pulse_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poweroff_o || reset_req_o) |-> $past(wr_ctl_i && trig_i));
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_sts_i,
  input  logic        wr_en_i,
  input  logic        wr_ctl_i,
  input  logic [15:0] wdata_i,
  input  logic [2:0]  evt_i,      // {rtc, pwrbtn, gbl}
  input  logic        ovf_i,
  input  logic        wake_set_i,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_i,
  input  logic        smi_en_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic [15:0] ctl_o,
  output logic        rearm_o,
  output logic        sci_o,
  output logic        smi_o
);
  logic [15:0] sts_q, en_q, ctl_q, sts_d, ctl_d;
  logic        clr_tmr;

  assign clr_tmr = wr_sts_i & wdata_i[B_TMR];
  assign rearm_o = clr_tmr & sts_q[B_TMR];

  always_comb begin
    sts_d = sts_q;
    if (wr_sts_i) sts_d = sts_d & ~wdata_i;
    if (evt_i[2]) sts_d[B_RTC] = 1'b1;
    if (evt_i[1]) sts_d[B_PWR] = 1'b1;
    if (evt_i[0]) sts_d[B_GBL] = 1'b1;
    if (wake_set_i) begin
      sts_d[B_WAKE] = 1'b1;
      sts_d[B_PWR]  = 1'b1;
    end
    if (ovf_i && !clr_tmr) sts_d[B_TMR] = 1'b1;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl_i) begin
      ctl_d = wdata_i;
      ctl_d[B_TRIG] = 1'b0;
    end
    if (cmd_we_i) begin
      if (cmd_i == CMD_ON)       ctl_d[0] = 1'b1;
      else if (cmd_i == CMD_OFF) ctl_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      sci_o <= 1'b0;
      smi_o <= 1'b0;
    end else begin
      sts_q <= sts_d;
      ctl_q <= ctl_d;
      if (wr_en_i) en_q <= wdata_i;
      sci_o <= |(sts_q & en_q & SCI_MASK);
      smi_o <= cmd_we_i & smi_en_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;

  assert_ovf_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |=> !sts_q[B_TMR]);
  assert_sci_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> ($past(en_q) & SCI_MASK) != 16'h0);
  assert_trig_not_stored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> !ctl_q[B_TRIG]);
  assert_smi_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(cmd_we_i && smi_en_i));
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        io_en_i,
  input  logic        smi_en_i,
  input  logic        hit_i,
  input  logic        we_i,
  input  logic [5:0]  off_i,
  input  logic [15:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rtc_evt_i,
  input  logic        pwrbtn_evt_i,
  input  logic        gbl_evt_i,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_i,
  output logic        sci_o,
  output logic        smi_o,
  output logic        poweroff_o,
  output logic        reset_req_o
);
  logic             wr, wr_sts, wr_en, wr_ctl, rearm, ovf, wake_set;
  logic [TMR_W-1:0] cnt;
  logic [15:0]      sts, en, ctl;

  assign wr     = hit_i & we_i & io_en_i;
  assign wr_sts = wr & (off_i == OFF_STS);
  assign wr_en  = wr & (off_i == OFF_EN);
  assign wr_ctl = wr & (off_i == OFF_CTL);

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rearm_i(rearm),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  pm_sleep u_slp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctl_i   (wr_ctl),
    .trig_i     (wdata_i[B_TRIG]),
    .typ_i      (wdata_i[B_TYP+2:B_TYP]),
    .wake_set_o (wake_set),
    .poweroff_o (poweroff_o),
    .reset_req_o(reset_req_o)
  );

  pm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_sts_i  (wr_sts),
    .wr_en_i   (wr_en),
    .wr_ctl_i  (wr_ctl),
    .wdata_i   (wdata_i),
    .evt_i     ({rtc_evt_i, pwrbtn_evt_i, gbl_evt_i}),
    .ovf_i     (ovf),
    .wake_set_i(wake_set),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .smi_en_i  (smi_en_i),
    .sts_o     (sts),
    .en_o      (en),
    .ctl_o     (ctl),
    .rearm_o   (rearm),
    .sci_o     (sci_o),
    .smi_o     (smi_o)
  );

  always_comb begin
    rdata_o = '1;
    if (hit_i && io_en_i) begin
      case (off_i)
        OFF_STS: rdata_o = {16'h0, sts};
        OFF_EN:  rdata_o = {16'h0, en};
        OFF_CTL: rdata_o = {16'h0, ctl};
        OFF_TMR: rdata_o = 32'(cnt);
        6'h0C, 6'h18, 6'h1C, 6'h30, 6'h31, 6'h32: rdata_o = '0;
        default: rdata_o = '1;
      endcase
    end
  end

  assert_io_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_en_i |=> $stable(en));
  assert_io_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_en_i |-> rdata_o == 32'hFFFF_FFFF);
endmodule

// File: tb/pm_event_ctrl_test.sv
`timescale 1ns/1ps
module pm_event_ctrl_test;
  localparam int W  = 12;
  localparam int EW = W + 1;
  localparam logic [EW-1:0] H = EW'(1) << (W - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, io_en = 1, smi_en = 0, hit = 1, we = 0;
  logic [5:0] off = 0;
  logic [15:0] wdata = 0;
  logic rtc = 0, pwr = 0, gbl = 0, cmd_we = 0;
  logic [7:0] cmd = 0;
  logic [31:0] rdata;
  logic sci, smi, poff, rreq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pm_event_ctrl #(.TMR_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .io_en_i(io_en), .smi_en_i(smi_en),
    .hit_i(hit), .we_i(we), .off_i(off), .wdata_i(wdata), .rdata_o(rdata),
    .rtc_evt_i(rtc), .pwrbtn_evt_i(pwr), .gbl_evt_i(gbl), .cmd_we_i(cmd_we),
    .cmd_i(cmd), .sci_o(sci), .smi_o(smi), .poweroff_o(poff), .reset_req_o(rreq)
  );

  // reference model built from the requirements
  logic [EW-1:0] m_ext, m_bnd, m_diff;
  logic [15:0] m_sts, m_en, m_ctl, m_nsts, m_nctl;
  logic m_sci, m_smi, m_off, m_rr, m_wr, m_clr0, m_rearm, m_trig, m_hit;

  always_comb begin
    m_wr    = hit && we && io_en;
    m_clr0  = m_wr && off == 6'h00 && wdata[0];
    m_rearm = m_clr0 && m_sts[0];
    m_trig  = m_wr && off == 6'h04 && wdata[13];
    m_diff  = m_ext - m_bnd;
    m_hit   = !m_diff[W];
    m_nsts  = m_sts;
    if (m_wr && off == 6'h00) m_nsts = m_nsts & ~wdata;
    if (rtc) m_nsts[10] = 1;
    if (pwr) m_nsts[8] = 1;
    if (gbl) m_nsts[5] = 1;
    if (m_trig && wdata[12:10] == 3'd1) begin m_nsts[15] = 1; m_nsts[8] = 1; end
    if (m_hit && !m_clr0) m_nsts[0] = 1;
    m_nctl = m_ctl;
    if (m_wr && off == 6'h04) m_nctl = wdata & 16'hDFFF;
    if (cmd_we && cmd == 8'hF1) m_nctl[0] = 1;
    if (cmd_we && cmd == 8'hF0) m_nctl[0] = 0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ext <= 0; m_bnd <= {1'b0, {W{1'b1}}};
      m_sts <= 0; m_en <= 0; m_ctl <= 0;
      m_sci <= 0; m_smi <= 0; m_off <= 0; m_rr <= 0;
    end else begin
      m_ext <= m_ext + EW'(tick);
      if (m_rearm) m_bnd <= (m_ext + H) & ~(H - EW'(1));
      m_sts <= m_nsts;
      m_ctl <= m_nctl;
      if (m_wr && off == 6'h02) m_en <= wdata;
      m_sci <= |(m_sts & m_en & 16'h0521);
      m_smi <= cmd_we && smi_en;
      m_off <= m_trig && wdata[12:10] == 3'd0;
      m_rr  <= m_trig && wdata[12:10] == 3'd1;
    end
  end

  function automatic logic [31:0] exp_read(logic [5:0] o);
    if (!hit || !io_en) return 32'hFFFF_FFFF;
    case (o)
      6'h00: return {16'h0, m_sts};
      6'h02: return {16'h0, m_en};
      6'h04: return {16'h0, m_ctl};
      6'h08: return 32'(m_ext[W-1:0]);
      6'h0C, 6'h18, 6'h1C, 6'h30, 6'h31, 6'h32: return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one cycle: compare everything against the model, then advance
  task automatic run();
    #1;
    chk(rdata == exp_read(off), "R2 read", rdata, exp_read(off));
    chk(sci == m_sci, "R6 sci", 32'(sci), 32'(m_sci));
    chk(smi == m_smi, "R8 smi", 32'(smi), 32'(m_smi));
    chk(poff == m_off, "R7 poweroff", 32'(poff), 32'(m_off));
    chk(rreq == m_rr, "R7 reset_req", 32'(rreq), 32'(m_rr));
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] o, input logic [15:0] d);
    off = o; wdata = d; we = 1; run(); we = 0;
  endtask

  task automatic rd_lit(input logic [5:0] o, input logic [31:0] e, input string tag);
    off = o; we = 0; #1;
    chk(rdata == e, tag, rdata, e);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    rd_lit(6'h00, 0, "R9 status");
    rd_lit(6'h02, 0, "R9 enable");
    rd_lit(6'h04, 0, "R9 control");
    rd_lit(6'h08, 0, "R9 timer");
    chk(!sci && !smi && !poff && !rreq, "R9 outputs", {sci, smi, poff, rreq}, 0);
    // R2 fixed and undefined offsets
    rd_lit(6'h30, 0, "R2 zero offset");
    rd_lit(6'h1C, 0, "R2 zero offset");
    rd_lit(6'h06, 32'hFFFF_FFFF, "R2 undefined");
    rd_lit(6'h3F, 32'hFFFF_FFFF, "R2 undefined");
    hit = 0; rd_lit(6'h02, 32'hFFFF_FFFF, "R2 no hit"); hit = 1;
    // R3 decoding disabled
    io_en = 0; wr(6'h02, 16'hFFFF);
    rd_lit(6'h02, 32'hFFFF_FFFF, "R3 read blocked");
    io_en = 1; rd_lit(6'h02, 0, "R3 write ignored");
    // R1 timer
    tick = 1; repeat (10) run(); tick = 0;
    rd_lit(6'h08, 10, "R1 timer count");
    // R4 events and write-one-to-clear
    rtc = 1; gbl = 1; run(); rtc = 0; gbl = 0;
    rd_lit(6'h00, 32'h0420, "R4 events set");
    wr(6'h00, 16'h0400);
    rd_lit(6'h00, 32'h0020, "R4 w1c");
    // R6 interrupt
    wr(6'h02, 16'h0021);
    run();
    chk(sci == 1, "R6 sci high", 32'(sci), 1);
    wr(6'h00, 16'h0020); run();
    chk(sci == 0, "R6 sci low", 32'(sci), 0);
    // R5 overflow and boundary move
    tick = 1;
    repeat (4100) run();
    rd_lit(6'h00, 32'h0001, "R5 overflow set");
    wr(6'h00, 16'h0001);
    repeat (2100) run();
    tick = 0;
    // R7 sleep requests
    wr(6'h04, 16'h2000);
    chk(poff == 1, "R7 power-off pulse", 32'(poff), 1);
    rd_lit(6'h04, 0, "R7 trigger not stored");
    chk(poff == 0, "R7 pulse width", 32'(poff), 0);
    wr(6'h04, 16'h2403);
    chk(rreq == 1, "R7 reset pulse", 32'(rreq), 1);
    rd_lit(6'h04, 32'h0403, "R7 control value");
    chk((rdata & 32'h8100) == 32'h0, "R7 offset moved", rdata, 0);
    off = 6'h00; #1; chk((rdata & 32'h8100) == 32'h8100, "R7 wake bits", rdata, 32'h8100);
    @(negedge clk);
    wr(6'h04, 16'h2C00);
    chk(!poff && !rreq, "R7 other type", {poff, rreq}, 0);
    // R8 command port
    smi_en = 1; cmd = 8'hF0; cmd_we = 1; run(); cmd_we = 0;
    chk(smi == 1, "R8 smi pulse", 32'(smi), 1);
    rd_lit(6'h04, 32'h0C00, "R8 disable cmd");
    smi_en = 0; cmd = 8'hF1; cmd_we = 1; wr(6'h04, 16'h0000); cmd_we = 0;
    chk(smi == 0, "R8 smi gated", 32'(smi), 0);
    rd_lit(6'h04, 32'h0001, "R8 cmd over write");
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      logic [5:0] offs [10] = '{6'h00, 6'h02, 6'h04, 6'h08, 6'h0C, 6'h18, 6'h31, 6'h32, 6'h01, 6'h3E};
      tick   = ($urandom % 4) != 0;
      io_en  = ($urandom % 8) != 0;
      hit    = ($urandom % 8) != 0;
      we     = ($urandom % 3) == 0;
      off    = ($urandom % 5 == 0) ? 6'($urandom) : offs[$urandom % 10];
      wdata  = 16'($urandom);
      if (off == 6'h04 && ($urandom % 8) != 0) wdata[13] = 0;
      rtc    = ($urandom % 16) == 0;
      pwr    = ($urandom % 16) == 0;
      gbl    = ($urandom % 16) == 0;
      cmd_we = ($urandom % 10) == 0;
      cmd    = ($urandom % 3 == 0) ? 8'hF1 : ($urandom % 2 == 0) ? 8'hF0 : 8'($urandom);
      smi_en = $urandom % 2;
      run();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule